// File: doc/BRIEF.md
# Pipeline Misprediction Squash Controller

This block owns the valid flags and the fetch address of a four-step in-order pipeline: fetch, decode, execute (where branches are resolved) and write-back. Each stage register holds an instruction word, its address and a valid flag. A fetched word is captured into decode on every clock edge. It then moves to execute and then to write-back, one stage per edge. Instructions never stall.

When the execute stage reports that its branch went the wrong way, one mispredict line reaches every earlier stage at once. On the next edge the decode and execute slots become bubbles, and the fetch address jumps to the corrected target. The branch itself moves on to write-back as normal. The decode stage may also ask for an earlier redirect, for example for an unconditional jump. That request discards only the word being fetched, and it loses to a mispredict from execute raised in the same cycle. Register-file and memory write enables leave the block only from write-back, and only for a valid instruction. No write from a wrong-path slot can therefore reach architectural state.

Top module: `squash_ctrl`

## Requirements
- R1: While reset is held, every stage valid flag reads 0, both write enables read 0 and the fetch address equals RESET_PC (0 by default).
- R2: With no redirect, the fetch address rises by one every cycle. A word fetched at address A appears in write-back, valid, three edges after it was fetched, and words leave in fetch order.
- R3: A mispredict raised while the execute slot is valid turns the decode and execute slots into bubbles on the next edge.
- R4: On that same edge the fetch address takes the corrected target presented with the mispredict.
- R5: The mispredicting instruction is not squashed. It reaches write-back, valid, on the next edge.
- R6: A mispredict raised while the execute slot is empty has no effect. Fetch continues sequentially and decode captures the fetched word.
- R7: A decode redirect raised while the decode slot is valid makes only the next decode slot a bubble and loads the fetch address with the decode target. The redirecting instruction moves on to execute.
- R8: When an execute mispredict and a decode redirect are both raised in one cycle, the execute target is loaded and both younger slots are squashed.
- R9: The register write enable equals write-back valid AND bit 0 of the write-back word. The memory write enable equals write-back valid AND bit 1 of that word. A bubble drives neither.
- R10: After a redirect, write-back shows exactly two bubbles from a mispredict, or one from a decode redirect. The word at the target address then arrives, valid, on the third edge after the redirect.
- R11: A decode redirect raised while the decode slot is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc_o | output | PC_W | Address being fetched this cycle |
| fetch_insn_i | input | INSN_W | Word returned for fetch_pc_o in the same cycle |
| dec_valid_o | output | 1 | Decode slot holds a live instruction |
| dec_pc_o | output | PC_W | Address of the decode slot |
| dec_insn_o | output | INSN_W | Word in the decode slot |
| id_redirect_i | input | 1 | Decode asks to jump to id_target_i |
| id_target_i | input | PC_W | Decode redirect address |
| exe_valid_o | output | 1 | Execute slot holds a live instruction |
| exe_pc_o | output | PC_W | Address of the execute slot |
| exe_insn_o | output | INSN_W | Word in the execute slot |
| ex_mispredict_i | input | 1 | Branch in execute was mispredicted |
| ex_target_i | input | PC_W | Corrected branch address |
| wb_valid_o | output | 1 | Write-back slot holds a live instruction |
| wb_pc_o | output | PC_W | Address of the write-back slot |
| wb_insn_o | output | INSN_W | Word in the write-back slot |
| rf_we_o | output | 1 | Register-file write enable |
| mem_we_o | output | 1 | Memory write enable |

## Verification
The two events that can land in one cycle are an execute mispredict and a decode redirect. The bench provokes this by raising both requests on the same low clock phase, while decode and execute both hold live instructions and the two targets differ. It then judges the outcome at the ports. The fetch address must equal the execute target. Both younger slots must read empty. The write-back stream must carry the branch, two bubbles and then the word at the execute target, and never the word at the decode target. A scoreboard records every address that was squashed and flags any write enable raised by such an address or by an empty slot.

// File: rtl/sq_pkg.sv
// Shared definitions for the squash controller.
// Assumes instruction words are at least two bits wide.
package sq_pkg;
    // Bit positions of the write requests inside an instruction word.
    localparam int RF_WE_BIT  = 0;
    localparam int MEM_WE_BIT = 1;

    // Source that selects the next fetch address.
    typedef enum logic [1:0] {
        SRC_SEQ = 2'd0,
        SRC_DEC = 2'd1,
        SRC_EXE = 2'd2
    } redir_src_e;
endpackage

// File: rtl/sq_pc_gen.sv
// Fetch address register with redirect arbitration.
// The execute-stage redirect (older instruction) beats the decode redirect;
// with neither, the address advances by one word.
// Assumes the flush inputs are already qualified by their slot's valid flag.
module sq_pc_gen
    import sq_pkg::*;
#(
    parameter int              PC_W     = 16,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exe_flush,
    input  logic [PC_W-1:0] exe_target,
    input  logic            dec_flush,
    input  logic [PC_W-1:0] dec_target,
    output logic [PC_W-1:0] pc_o
);
    redir_src_e      src;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_nxt;

    // Pick the redirect source, oldest instruction first.
    always_comb begin
        src = SRC_SEQ;
        if (exe_flush)      src = SRC_EXE;
        else if (dec_flush) src = SRC_DEC;
    end

    // Form the next fetch address from the chosen source.
    always_comb begin
        case (src)
            SRC_EXE: pc_nxt = exe_target;
            SRC_DEC: pc_nxt = dec_target;
            default: pc_nxt = pc_q + PC_W'(1);
        endcase
    end

    // Hold the fetch address.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= RESET_PC;
        else        pc_q <= pc_nxt;
    end

    assign pc_o = pc_q;
endmodule

// File: rtl/sq_stage.sv
// One pipeline stage register: payload plus valid flag.
// A kill turns the captured instruction into a bubble; the payload is still
// loaded but is never used while the flag is low.
module sq_stage #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_valid,
    input  logic [W-1:0] load_data,
    input  logic         kill,
    output logic         q_valid,
    output logic [W-1:0] q_data
);
    // Capture the upstream slot, clearing its flag when killed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_data  <= '0;
        end else begin
            q_valid <= load_valid & ~kill;
            q_data  <= load_data;
        end
    end
endmodule

// File: rtl/sq_wb_gate.sv
// Write-enable gating at write-back: a request bit counts only when the
// slot is valid. Assumes the request bits are taken from the word directly.
module sq_wb_gate (
    input  logic valid,
    input  logic rf_req,
    input  logic mem_req,
    output logic rf_we,
    output logic mem_we
);
    // Mask both requests with the slot valid flag.
    always_comb begin
        rf_we  = valid & rf_req;
        mem_we = valid & mem_req;
    end
endmodule

// File: rtl/squash_ctrl.sv
// Misprediction squash controller for a fetch/decode/execute/write-back pipe.
// Slot index 0 is the fetch side, 1 decode, 2 execute, 3 write-back.
// A mispredict in execute kills every load into a younger slot; a decode
// redirect kills only the load from fetch. Assumes fetch_insn_i answers
// fetch_pc_o in the same cycle and that nothing stalls.
module squash_ctrl
    import sq_pkg::*;
#(
    parameter int              PC_W     = 16,
    parameter int              INSN_W   = 16,
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [PC_W-1:0]   fetch_pc_o,
    input  logic [INSN_W-1:0] fetch_insn_i,
    output logic              dec_valid_o,
    output logic [PC_W-1:0]   dec_pc_o,
    output logic [INSN_W-1:0] dec_insn_o,
    input  logic              id_redirect_i,
    input  logic [PC_W-1:0]   id_target_i,
    output logic              exe_valid_o,
    output logic [PC_W-1:0]   exe_pc_o,
    output logic [INSN_W-1:0] exe_insn_o,
    input  logic              ex_mispredict_i,
    input  logic [PC_W-1:0]   ex_target_i,
    output logic              wb_valid_o,
    output logic [PC_W-1:0]   wb_pc_o,
    output logic [INSN_W-1:0] wb_insn_o,
    output logic              rf_we_o,
    output logic              mem_we_o
);
    localparam int NSTG    = 3;
    localparam int SW      = PC_W + INSN_W;
    localparam int DEC_IDX = 1;
    localparam int EXE_IDX = 2;
    localparam int WB_IDX  = 3;

    logic            stg_v [NSTG+1];
    logic [SW-1:0]   stg_d [NSTG+1];
    logic [NSTG-1:0] kill;
    logic            exe_flush;
    logic            dec_flush;
    logic [PC_W-1:0] pc;

    // Qualify both redirect requests; the older one suppresses the newer.
    always_comb begin
        exe_flush = stg_v[EXE_IDX] & ex_mispredict_i;
        dec_flush = stg_v[DEC_IDX] & id_redirect_i & ~exe_flush;
    end

    // Broadcast the kills: execute flush reaches every load younger than it.
    always_comb begin
        for (int i = 0; i < NSTG; i++) begin
            kill[i] = ((i < EXE_IDX) && exe_flush) || ((i == 0) && dec_flush);
        end
    end

    sq_pc_gen #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_pc (
        .clk        (clk),
        .rst_n      (rst_n),
        .exe_flush  (exe_flush),
        .exe_target (ex_target_i),
        .dec_flush  (dec_flush),
        .dec_target (id_target_i),
        .pc_o       (pc)
    );

    assign stg_v[0] = 1'b1;
    assign stg_d[0] = {pc, fetch_insn_i};

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        sq_stage #(.W(SW)) u_stg (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_valid (stg_v[g]),
            .load_data  (stg_d[g]),
            .kill       (kill[g]),
            .q_valid    (stg_v[g+1]),
            .q_data     (stg_d[g+1])
        );
    end

    sq_wb_gate u_gate (
        .valid   (stg_v[WB_IDX]),
        .rf_req  (stg_d[WB_IDX][RF_WE_BIT]),
        .mem_req (stg_d[WB_IDX][MEM_WE_BIT]),
        .rf_we   (rf_we_o),
        .mem_we  (mem_we_o)
    );

    assign fetch_pc_o  = pc;
    assign dec_valid_o = stg_v[DEC_IDX];
    assign dec_pc_o    = stg_d[DEC_IDX][SW-1 -: PC_W];
    assign dec_insn_o  = stg_d[DEC_IDX][INSN_W-1:0];
    assign exe_valid_o = stg_v[EXE_IDX];
    assign exe_pc_o    = stg_d[EXE_IDX][SW-1 -: PC_W];
    assign exe_insn_o  = stg_d[EXE_IDX][INSN_W-1:0];
    assign wb_valid_o  = stg_v[WB_IDX];
    assign wb_pc_o     = stg_d[WB_IDX][SW-1 -: PC_W];
    assign wb_insn_o   = stg_d[WB_IDX][INSN_W-1:0];
endmodule

// File: rtl/squash_ctrl_chk.sv
// Property checker for squash_ctrl, attached through bind.
// Observes only the ports of the controller.
module squash_ctrl_chk #(
    parameter int PC_W   = 16,
    parameter int INSN_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   fetch_pc_o,
    input logic              dec_valid_o,
    input logic              id_redirect_i,
    input logic [PC_W-1:0]   id_target_i,
    input logic              exe_valid_o,
    input logic [PC_W-1:0]   exe_pc_o,
    input logic              ex_mispredict_i,
    input logic [PC_W-1:0]   ex_target_i,
    input logic              wb_valid_o,
    input logic [PC_W-1:0]   wb_pc_o,
    input logic [INSN_W-1:0] wb_insn_o,
    input logic              rf_we_o,
    input logic              mem_we_o
);
    // R2
    sequential_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(exe_valid_o && ex_mispredict_i) && !(dec_valid_o && id_redirect_i)
        |=> fetch_pc_o == $past(fetch_pc_o) + PC_W'(1));

    // R3
    younger_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exe_valid_o && ex_mispredict_i |=> !dec_valid_o && !exe_valid_o);

    // R4 R8
    exe_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exe_valid_o && ex_mispredict_i |=> fetch_pc_o == $past(ex_target_i));

    // R5
    branch_retires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exe_valid_o && ex_mispredict_i |=> wb_valid_o && wb_pc_o == $past(exe_pc_o));

    // R7
    dec_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_o && id_redirect_i && !(exe_valid_o && ex_mispredict_i)
        |=> fetch_pc_o == $past(id_target_i) && !dec_valid_o && exe_valid_o);

    // R9
    bubble_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_valid_o |-> !rf_we_o && !mem_we_o);

    // R9
    live_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> rf_we_o == wb_insn_o[0] && mem_we_o == wb_insn_o[1]);
endmodule

bind squash_ctrl squash_ctrl_chk #(.PC_W(PC_W), .INSN_W(INSN_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .fetch_pc_o      (fetch_pc_o),
    .dec_valid_o     (dec_valid_o),
    .id_redirect_i   (id_redirect_i),
    .id_target_i     (id_target_i),
    .exe_valid_o     (exe_valid_o),
    .exe_pc_o        (exe_pc_o),
    .ex_mispredict_i (ex_mispredict_i),
    .ex_target_i     (ex_target_i),
    .wb_valid_o      (wb_valid_o),
    .wb_pc_o         (wb_pc_o),
    .wb_insn_o       (wb_insn_o),
    .rf_we_o         (rf_we_o),
    .mem_we_o        (mem_we_o)
);

// File: tb/sim_squash_ctrl.sv
// Directed bench for squash_ctrl. Inputs change and outputs are sampled on
// the falling clock edge. The instruction memory returns, for address A, a
// word whose bit 0 is 1 (register write) and bit 1 is A[2] (memory write).
module sim_squash_ctrl;
    localparam int PW = 16;
    localparam int IW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] fetch_pc;
    logic [IW-1:0] fetch_insn;
    logic          dec_valid, exe_valid, wb_valid;
    logic [PW-1:0] dec_pc, exe_pc, wb_pc;
    logic [IW-1:0] dec_insn, exe_insn, wb_insn;
    logic          id_redirect = 1'b0;
    logic [PW-1:0] id_target = '0;
    logic          mispredict = 1'b0;
    logic [PW-1:0] ex_target = '0;
    logic          rf_we, mem_we;

    int            n_checks = 0;
    int            n_fail = 0;
    bit            done = 1'b0;
    logic [PW-1:0] killed [8];
    int            nkill = 0;

    always #5 clk = ~clk;

    assign fetch_insn = {fetch_pc[13:0], fetch_pc[2], 1'b1};

    squash_ctrl #(.PC_W(PW), .INSN_W(IW)) u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .fetch_pc_o      (fetch_pc),
        .fetch_insn_i    (fetch_insn),
        .dec_valid_o     (dec_valid),
        .dec_pc_o        (dec_pc),
        .dec_insn_o      (dec_insn),
        .id_redirect_i   (id_redirect),
        .id_target_i     (id_target),
        .exe_valid_o     (exe_valid),
        .exe_pc_o        (exe_pc),
        .exe_insn_o      (exe_insn),
        .ex_mispredict_i (mispredict),
        .ex_target_i     (ex_target),
        .wb_valid_o      (wb_valid),
        .wb_pc_o         (wb_pc),
        .wb_insn_o       (wb_insn),
        .rf_we_o         (rf_we),
        .mem_we_o        (mem_we)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic bit is_killed(input logic [PW-1:0] a);
        for (int i = 0; i < nkill; i++) if (killed[i] == a) return 1'b1;
        return 1'b0;
    endfunction

    task automatic mark_killed(input logic [PW-1:0] a);
        if (nkill < 8) begin
            killed[nkill] = a;
            nkill++;
        end
    endtask

    // Scoreboard: no write may come from a bubble or a squashed address (R9).
    always @(negedge clk) begin
        if (rst_n && (rf_we || mem_we)) begin
            check(wb_valid && !is_killed(wb_pc), "R9 squashed write", int'(wb_pc), -1);
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        mispredict = 1'b0;
        id_redirect = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        nkill = 0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step();
        step();
        check(!dec_valid && !exe_valid && !wb_valid, "R1 valids",
              int'({dec_valid, exe_valid, wb_valid}), 0);
        check(!rf_we && !mem_we, "R1 write enables", int'({rf_we, mem_we}), 0);
        check(fetch_pc == '0, "R1 fetch pc", int'(fetch_pc), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_sequential();
        do_reset();
        step(); step(); step();
        check(wb_valid && wb_pc == 16'h0, "R2 first retire", int'(wb_pc), 0);
        check(rf_we && !mem_we, "R9 word 0 enables", int'({rf_we, mem_we}), 2);
        check(fetch_pc == 16'h3, "R2 fetch advance", int'(fetch_pc), 3);
        for (int k = 1; k <= 6; k++) begin
            step();
            check(wb_valid && wb_pc == PW'(k), "R2 in order", int'(wb_pc), k);
            check(rf_we && mem_we == k[2], "R9 enables", int'({rf_we, mem_we}),
                  int'({1'b1, k[2]}));
            check(fetch_pc == PW'(k + 3), "R2 fetch advance", int'(fetch_pc), k + 3);
        end
    endtask

    task automatic t_mispredict();
        do_reset();
        step(); step(); step();
        check(exe_valid && exe_pc == 16'h1, "R3 setup", int'(exe_pc), 1);
        mark_killed(dec_pc);
        mark_killed(fetch_pc);
        mispredict = 1'b1;
        ex_target = 16'h104;
        step();
        mispredict = 1'b0;
        check(!dec_valid && !exe_valid, "R3 younger bubbles", int'({dec_valid, exe_valid}), 0);
        check(fetch_pc == 16'h104, "R4 redirect", int'(fetch_pc), 'h104);
        check(wb_valid && wb_pc == 16'h1 && rf_we, "R5 branch retires", int'(wb_pc), 1);
        step();
        check(!wb_valid && !rf_we && !mem_we, "R10 bubble 1", int'({wb_valid, rf_we, mem_we}), 0);
        step();
        check(!wb_valid && !rf_we && !mem_we, "R10 bubble 2", int'({wb_valid, rf_we, mem_we}), 0);
        step();
        check(wb_valid && wb_pc == 16'h104, "R10 target arrives", int'(wb_pc), 'h104);
        check(rf_we && mem_we, "R9 target enables", int'({rf_we, mem_we}), 3);
    endtask

    task automatic t_ignored();
        do_reset();
        step(); step(); step();
        mark_killed(dec_pc);
        mark_killed(fetch_pc);
        mispredict = 1'b1;
        ex_target = 16'h200;
        step();
        // Both decode and execute are now empty; these requests must do nothing.
        ex_target = 16'h300;
        id_redirect = 1'b1;
        id_target = 16'h380;
        step();
        mispredict = 1'b0;
        id_redirect = 1'b0;
        check(fetch_pc == 16'h201, "R6 R11 fetch continues", int'(fetch_pc), 'h201);
        check(dec_valid && dec_pc == 16'h200, "R6 R11 decode captured", int'(dec_pc), 'h200);
    endtask

    task automatic t_dec_redirect();
        do_reset();
        step(); step();
        check(dec_valid && dec_pc == 16'h1, "R7 setup", int'(dec_pc), 1);
        mark_killed(fetch_pc);
        id_redirect = 1'b1;
        id_target = 16'h54;
        step();
        id_redirect = 1'b0;
        check(fetch_pc == 16'h54, "R7 redirect", int'(fetch_pc), 'h54);
        check(!dec_valid, "R7 fetch slot squashed", int'(dec_valid), 0);
        check(exe_valid && exe_pc == 16'h1, "R7 redirector advances", int'(exe_pc), 1);
        step();
        check(wb_valid && wb_pc == 16'h1, "R7 redirector retires", int'(wb_pc), 1);
        step();
        check(!wb_valid, "R10 one bubble", int'(wb_valid), 0);
        step();
        check(wb_valid && wb_pc == 16'h54 && mem_we, "R10 decode target arrives",
              int'(wb_pc), 'h54);
    endtask

    task automatic t_both();
        do_reset();
        step(); step(); step();
        mark_killed(dec_pc);
        mark_killed(fetch_pc);
        mark_killed(16'h500);
        mispredict = 1'b1;
        ex_target = 16'h404;
        id_redirect = 1'b1;
        id_target = 16'h500;
        step();
        mispredict = 1'b0;
        id_redirect = 1'b0;
        check(fetch_pc == 16'h404, "R8 execute target wins", int'(fetch_pc), 'h404);
        check(!dec_valid && !exe_valid, "R8 both squashed", int'({dec_valid, exe_valid}), 0);
        step(); step(); step();
        check(wb_valid && wb_pc == 16'h404, "R8 stream follows execute target",
              int'(wb_pc), 'h404);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_sequential();
        t_mispredict();
        t_ignored();
        t_dec_redirect();
        t_both();
        step();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule